// File: doc/BRIEF.md
# Host Bus Wait-State Controller

This block connects a board to an asynchronous parallel host I/O bus. It watches the active-low chip select together with a 4-bit board identifier carried in the upper host address bits. When the board is addressed, it pulls the active-low wait line low and decodes a small select field of the address into one of several local targets: two DSP data ports, two DSP control ports, a FIFO and a register block. It then releases wait and issues a single-cycle read or write strobe together with a one-hot target enable.

For the two DSP data ports the cycle is stretched by that DSP's ready flag. The flag's meaning depends on direction: a high flag holds a write, and a low flag holds a read. The stretch is capped. Once the cap is reached, the controller gives up on the access, releases the host and emits a one-cycle timeout pulse for a separate interrupt block to latch. All host control inputs and the flags pass through two-stage synchronisers before they are used. The block handles one access per chip-select assertion.

Top module: `hostbus_wait_ctrl`

## Requirements
- R1: While and right after synchronous reset, `host_wait_n` is 1, and `tgt_rd_stb`, `tgt_wr_stb`, `tgt_en` and `timeout_pulse` are all 0.
- R2: An access is taken only when `host_cs_n` is 0 and `host_addr[21:18]` equals `board_id`. With any other identifier, `host_wait_n` stays 1 and no strobe or timeout is produced.
- R3: `host_wait_n` goes to 0 exactly 3 clock cycles after the edge at which the chip select is sampled low. This delay is two synchroniser stages plus the state register.
- R4: `host_addr[4:2]` selects the target, and `tgt_en` bit k marks target k. The codes are: 0 is the DSP0 data port, 1 is the DSP1 data port, 2 is the DSP0 control port, 3 is the DSP1 control port, 4 is the FIFO and 5 is the register block. `tgt_en` is never more than one-hot.
- R5: For an access that needs no stretching, `host_wait_n` returns to 1 one cycle after it fell. In that same cycle exactly one of `tgt_rd_stb` (when `host_rd_n` is 0) or `tgt_wr_stb` (when `host_wr_n` is 0) is high for one cycle, together with the target's `tgt_en` bit.
- R6: For a DSP data port, a write is held while that DSP's `dsp_flag` bit is 1, and a read is held while it is 0. Accesses to the other targets ignore the flags.
- R7: When a held access becomes ready, its strobe and the release of wait occur 3 cycles after the flag change is driven.
- R8: A held access gets at most 15 wait states. If it is still held, `host_wait_n` returns to 1 sixteen cycles after it fell, no strobe is issued, and `timeout_pulse` is high for exactly that one cycle.
- R9: Select codes 6 and 7 map to no target. The access still completes one cycle after wait falls, with no strobe, no enable and no timeout.
- R10: Only one strobe or timeout is produced per chip-select assertion, however long the chip select stays low. A new access begins only after the chip select has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | 22 | Host address; [21:18] board identifier, [4:2] target select |
| board_id | input | 4 | Identifier this board answers to |
| dsp_flag | input | 2 | Per-DSP data-port ready flag, asynchronous |
| host_wait_n | output | 1 | Wait request to host, active low |
| tgt_en | output | 6 | One-hot target enable, valid with a strobe |
| tgt_rd_stb | output | 1 | Single-cycle read strobe |
| tgt_wr_stb | output | 1 | Single-cycle write strobe |
| timeout_pulse | output | 1 | Single-cycle pulse when an access is abandoned |

## Verification
Every result is timed from the cycle count at which the bench drives the chip select low. Wait falls 3 cycles later. An unstretched access releases 1 cycle after that, a flag-released access releases 3 cycles after the flag change, and a timed-out access releases 16 cycles after wait fell. A driver task queues the expected kind, enable and release latency for each access. A monitor, sampling on the falling clock edge, measures the actual fall and release cycles and compares them with the queue head. Any strobe outside a release cycle counts as an extra event.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_STALL  = 2'd2,
    ST_HOLD   = 2'd3
  } hbw_state_t;
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hbw_decode.sv
module hbw_decode #(
  parameter int ID_W  = 4,
  parameter int SEL_W = 3,
  parameter int NTGT  = 6,
  parameter int NDSP  = 2,
  localparam int DIW  = (NDSP > 1) ? $clog2(NDSP) : 1
) (
  input  logic [ID_W-1:0]  addr_id,
  input  logic [ID_W-1:0]  board_id,
  input  logic [SEL_W-1:0] addr_sel,
  output logic             id_hit,
  output logic [NTGT-1:0]  tgt_oh,
  output logic             dsp_data,
  output logic [DIW-1:0]   dsp_idx
);
  assign id_hit = (addr_id == board_id);

  // Target k answers to select code k; DSP data ports occupy codes 0..NDSP-1.
  for (genvar k = 0; k < NTGT; k++) begin : g_tgt
    assign tgt_oh[k] = (addr_sel == SEL_W'(k));
  end

  assign dsp_data = (int'(addr_sel) < NDSP);
  assign dsp_idx  = DIW'(addr_sel);
endmodule

// File: rtl/hbw_fsm.sv
module hbw_fsm
  import hbw_pkg::*;
#(
  parameter int NTGT     = 6,
  parameter int NDSP     = 2,
  parameter int MAX_WAIT = 15,
  localparam int DIW     = (NDSP > 1) ? $clog2(NDSP) : 1,
  localparam int CNT_W   = $clog2(MAX_WAIT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_act,
  input  logic            id_hit,
  input  logic            rd_act,
  input  logic            wr_act,
  input  logic [NDSP-1:0] flag_s,
  input  logic [NTGT-1:0] tgt_oh,
  input  logic            dsp_data,
  input  logic [DIW-1:0]  dsp_idx,
  output logic            wait_n_q,
  output logic [NTGT-1:0] en_q,
  output logic            rd_q,
  output logic            wr_q,
  output logic            to_q
);
  hbw_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             dir_q;
  logic             dir_now;
  logic             blocked;

  assign dir_now = (state == ST_DECODE) ? (wr_act && !rd_act) : dir_q;
  assign blocked = dsp_data && (dir_now ? flag_s[dsp_idx] : !flag_s[dsp_idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wait_n_q <= 1'b1;
      en_q     <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      to_q     <= 1'b0;
      cnt      <= '0;
      dir_q    <= 1'b0;
    end else begin
      en_q <= '0;
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      to_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cs_act && id_hit) begin
            state    <= ST_DECODE;
            wait_n_q <= 1'b0;
          end
        end
        ST_DECODE: begin
          if (!cs_act) begin
            state    <= ST_IDLE;
            wait_n_q <= 1'b1;
          end else if (rd_act || wr_act) begin
            dir_q <= dir_now;
            cnt   <= '0;
            if (blocked) begin
              state <= ST_STALL;
            end else begin
              state    <= ST_HOLD;
              wait_n_q <= 1'b1;
              if (|tgt_oh) begin
                en_q <= tgt_oh;
                rd_q <= !dir_now;
                wr_q <= dir_now;
              end
            end
          end
        end
        ST_STALL: begin
          if (!blocked) begin
            state    <= ST_HOLD;
            wait_n_q <= 1'b1;
            en_q     <= tgt_oh;
            rd_q     <= !dir_now;
            wr_q     <= dir_now;
          end else if (cnt == CNT_W'(MAX_WAIT - 1)) begin
            state    <= ST_HOLD;
            wait_n_q <= 1'b1;
            to_q     <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (!cs_act) state <= ST_IDLE;
        end
      endcase
    end
  end

  assert_dec_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_oh));
  assert_stb_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_q || wr_q) |-> $onehot(en_q));
  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));
  assert_stb_released_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_q || wr_q || to_q) |-> wait_n_q);
  assert_no_stb_on_to_R8: assert property (@(posedge clk) disable iff (rst)
    to_q |-> (!rd_q && !wr_q && en_q == '0));
  assert_cnt_cap_R8: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= MAX_WAIT - 1);
  assert_to_single_R8: assert property (@(posedge clk) disable iff (rst)
    to_q |=> !to_q);
  assert_one_event_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_q || wr_q || to_q) |=> !(rd_q || wr_q || to_q));
endmodule

// File: rtl/hostbus_wait_ctrl.sv
module hostbus_wait_ctrl #(
  parameter int ADDR_W   = 22,
  parameter int ID_LSB   = 18,
  parameter int ID_W     = 4,
  parameter int SEL_LSB  = 2,
  parameter int SEL_W    = 3,
  parameter int NTGT     = 6,
  parameter int NDSP     = 2,
  parameter int MAX_WAIT = 15,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [ID_W-1:0]   board_id,
  input  logic [NDSP-1:0]   dsp_flag,
  output logic              host_wait_n,
  output logic [NTGT-1:0]   tgt_en,
  output logic              tgt_rd_stb,
  output logic              tgt_wr_stb,
  output logic              timeout_pulse
);
  localparam int DIW = (NDSP > 1) ? $clog2(NDSP) : 1;

  logic [2:0]      ctl_s;
  logic [NDSP-1:0] flag_s;
  logic            id_hit;
  logic [NTGT-1:0] tgt_oh;
  logic            dsp_data;
  logic [DIW-1:0]  dsp_idx;
  logic            unused_addr;

  assign unused_addr = ^host_addr;

  hbw_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .din({host_cs_n, host_rd_n, host_wr_n}),
    .dout(ctl_s)
  );

  hbw_sync #(.W(NDSP), .STAGES(SYNC_STG), .RST_VAL('0)) u_flag_sync (
    .clk(clk), .rst(rst), .din(dsp_flag), .dout(flag_s)
  );

  hbw_decode #(.ID_W(ID_W), .SEL_W(SEL_W), .NTGT(NTGT), .NDSP(NDSP)) u_dec (
    .addr_id(host_addr[ID_LSB +: ID_W]),
    .board_id(board_id),
    .addr_sel(host_addr[SEL_LSB +: SEL_W]),
    .id_hit(id_hit),
    .tgt_oh(tgt_oh),
    .dsp_data(dsp_data),
    .dsp_idx(dsp_idx)
  );

  hbw_fsm #(.NTGT(NTGT), .NDSP(NDSP), .MAX_WAIT(MAX_WAIT)) u_fsm (
    .clk(clk), .rst(rst),
    .cs_act(!ctl_s[2]),
    .id_hit(id_hit),
    .rd_act(!ctl_s[1]),
    .wr_act(!ctl_s[0]),
    .flag_s(flag_s),
    .tgt_oh(tgt_oh),
    .dsp_data(dsp_data),
    .dsp_idx(dsp_idx),
    .wait_n_q(host_wait_n),
    .en_q(tgt_en),
    .rd_q(tgt_rd_stb),
    .wr_q(tgt_wr_stb),
    .to_q(timeout_pulse)
  );
endmodule

// File: tb/hostbus_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module hostbus_wait_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [21:0] host_addr = '0;
  logic [3:0]  board_id = 4'hA;
  logic [1:0]  dsp_flag = 2'b00;
  logic        host_wait_n, tgt_rd_stb, tgt_wr_stb, timeout_pulse;
  logic [5:0]  tgt_en;

  always #2.5 clk = ~clk;

  hostbus_wait_ctrl dut_i (
    .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_addr(host_addr), .board_id(board_id),
    .dsp_flag(dsp_flag), .host_wait_n(host_wait_n), .tgt_en(tgt_en),
    .tgt_rd_stb(tgt_rd_stb), .tgt_wr_stb(tgt_wr_stb),
    .timeout_pulse(timeout_pulse)
  );

  typedef struct {
    int         kind;   // 0 read, 1 write, 2 timeout, 3 none
    logic [5:0] en;
    int         lat;
    int         start;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, fails = 0, cyc = 0, falls = 0, fall_cyc = 0;
  bit   prev_wait = 1'b1, done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (!host_wait_n && prev_wait) begin
        fall_cyc = cyc;
        falls++;
      end
      if (host_wait_n && !prev_wait) begin
        int kobs;
        kobs = tgt_rd_stb ? 0 : tgt_wr_stb ? 1 : timeout_pulse ? 2 : 3;
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected completed cycle", 1, 0);
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(kobs == it.kind, it.req, "event kind", kobs, it.kind);
          chk(tgt_en == it.en, "R4", "target enable", int'(tgt_en), int'(it.en));
          chk(cyc - fall_cyc == it.lat, it.req, "release latency", cyc - fall_cyc, it.lat);
          chk(fall_cyc - it.start == 3, "R3", "wait assert delay", fall_cyc - it.start, 3);
        end
      end else if (tgt_rd_stb || tgt_wr_stb || timeout_pulse) begin
        chk(0, "R10", "extra strobe outside release", 1, 0);
      end
      prev_wait = host_wait_n;
    end
  end

  task automatic access(input logic [2:0] sel, input bit wr, input logic [3:0] id,
                        input bit push, input int kind, input logic [5:0] en,
                        input int lat, input string req,
                        input int flip_at, input int fidx, input bit fval);
    @(negedge clk);
    if (push) begin
      exp_t it;
      it.kind = kind; it.en = en; it.lat = lat; it.start = cyc; it.req = req;
      q.push_back(it);
    end
    host_addr = {id, 13'b0, sel, 2'b00};
    host_cs_n = 1'b0;
    host_rd_n = wr;
    host_wr_n = !wr;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (i == flip_at) dsp_flag[fidx] = fval;
    end
    host_cs_n = 1'b1;
    host_rd_n = 1'b1;
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(host_wait_n == 1'b1, "R1", "wait after reset", host_wait_n, 1);
    chk({tgt_rd_stb, tgt_wr_stb, timeout_pulse} == 3'b000, "R1", "strobes after reset",
        {tgt_rd_stb, tgt_wr_stb, timeout_pulse}, 0);
    chk(tgt_en == 6'd0, "R1", "enable after reset", tgt_en, 0);

    // R5: unstretched read of FIFO, write of registers
    access(3'd4, 1'b0, 4'hA, 1, 0, 6'b010000, 1, "R5", 0, 0, 0);
    access(3'd5, 1'b1, 4'hA, 1, 1, 6'b100000, 1, "R5", 0, 0, 0);
    // R6: DSP data ports ready, no stretching
    dsp_flag = 2'b10;
    repeat (4) @(negedge clk);
    access(3'd0, 1'b1, 4'hA, 1, 1, 6'b000001, 1, "R6", 0, 0, 0);
    access(3'd1, 1'b0, 4'hA, 1, 0, 6'b000010, 1, "R6", 0, 0, 0);
    // R7: write to DSP0 held by high flag, released at negedge 5
    dsp_flag = 2'b01;
    repeat (4) @(negedge clk);
    access(3'd0, 1'b1, 4'hA, 1, 1, 6'b000001, 5, "R7", 5, 0, 1'b0);
    // R8: read of DSP1 held by low flag until timeout
    dsp_flag = 2'b00;
    repeat (4) @(negedge clk);
    access(3'd1, 1'b0, 4'hA, 1, 2, 6'b000000, 16, "R8", 0, 0, 0);
    // R6: control port ignores a blocking flag
    dsp_flag = 2'b01;
    repeat (4) @(negedge clk);
    access(3'd2, 1'b1, 4'hA, 1, 1, 6'b000100, 1, "R6", 0, 0, 0);
    // R9: unmapped codes
    access(3'd6, 1'b0, 4'hA, 1, 3, 6'b000000, 1, "R9", 0, 0, 0);
    access(3'd7, 1'b1, 4'hA, 1, 3, 6'b000000, 1, "R9", 0, 0, 0);
    // R2: identifier mismatch is ignored
    begin
      int f0;
      f0 = falls;
      access(3'd4, 1'b0, 4'h3, 0, 0, 6'b0, 0, "R2", 0, 0, 0);
      chk(falls == f0, "R2", "wait asserted on foreign id", falls - f0, 0);
    end
    // R7: read of DSP0 held by low flag, released by raising it; R10 back-to-back
    dsp_flag = 2'b00;
    repeat (4) @(negedge clk);
    access(3'd0, 1'b0, 4'hA, 1, 0, 6'b000001, 5, "R7", 5, 0, 1'b1);
    access(3'd3, 1'b0, 4'hA, 1, 0, 6'b001000, 1, "R10", 0, 0, 0);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "pending expected events", q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule